// File: doc/BRIEF.md
# TLB-Backed Virtual Address Translator

This block turns a virtual address into a physical address for a processor-side client. The virtual address is split into a virtual page number (upper bits) and a byte offset (lower bits). The block first searches a small fully associative translation buffer. On a hit it answers in the next cycle and does not touch memory. On a miss it reads one entry of a direct-mapped page table held in external memory. The entry is selected by the virtual page number, so a page number of N bits addresses a table of 2^N entries. If that entry is resident, the translation is loaded into the buffer and returned. If it is not resident, the block reports a page fault.

A miss in the buffer and a page fault are separate outcomes. The response carries one flag for the buffer hit and another for the fault. When a write reaches a resident page whose dirty flag is clear, the block writes the page table entry back with its dirty flag set. Software may empty the whole buffer in one cycle with a flush input, for example after it has changed the table. Servicing the fault, which means loading the page and marking its entry valid, is the job of the surrounding system.

Top module: `vat_mmu`

## Requirements
- R1: The physical address is the physical page number from the translation, placed above the offset. The offset (the low OFF_W bits of the virtual address) passes through unchanged.
- R2: When an accepted request hits the buffer, resp_valid and resp_tlb_hit are high in the cycle after acceptance, and no page table read is issued.
- R3: When an accepted request misses the buffer, pt_rd_en pulses for one cycle in the cycle after acceptance, with pt_rd_idx equal to the virtual page number. The response follows one cycle after pt_rd_ack, with resp_tlb_hit low.
- R4: A fault is reported only when the fetched page table entry has its valid bit clear. A fault response has resp_tlb_hit low and resp_paddr zero. It loads nothing into the buffer, so the next access to that page walks the table again.
- R5: A page table entry that is valid after a buffer miss is loaded into the buffer. A later access to the same page hits.
- R6: Page table entry layout, PPN_W+2 bits wide: bit PPN_W+1 is valid, bit PPN_W is dirty, bits PPN_W-1..0 are the physical page number.
- R7: A write to a resident page whose dirty bit is clear causes one page table write, at the page number, of the entry with both valid and dirty set and the physical page number unchanged. This holds on both the buffer-hit path and the walk path. Later writes to the same page, reads, and faulting writes cause no page table write.
- R8: A refill goes to the lowest-numbered empty buffer entry. When the buffer is full, a round-robin pointer picks the victim. It starts at entry 0, moves on by one after each eviction, and ignores hits.
- R9: A flush pulse empties every buffer entry in one cycle and resets the round-robin pointer to 0. A refill that lands in the same cycle as a flush is dropped.
- R10: After reset the buffer is empty, req_ready is high, and resp_valid, pt_rd_en and pt_wr_en are low.
- R11: req_ready is low while a table walk is outstanding and while flush is high. A request offered while req_ready is low is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Empty the translation buffer |
| req_valid | input | 1 | Translation request |
| req_write | input | 1 | Request is a write access |
| req_vaddr | input | VPN_W+OFF_W | Virtual address |
| req_ready | output | 1 | Request accepted when high with req_valid |
| resp_valid | output | 1 | Response strobe |
| resp_tlb_hit | output | 1 | Response came from the buffer |
| resp_fault | output | 1 | Page fault |
| resp_paddr | output | PPN_W+OFF_W | Physical address, zero on a fault |
| pt_rd_en | output | 1 | Page table read strobe |
| pt_rd_idx | output | VPN_W | Page table read index |
| pt_rd_ack | input | 1 | Read data valid |
| pt_rd_data | input | PPN_W+2 | Page table entry read |
| pt_wr_en | output | 1 | Page table write strobe |
| pt_wr_idx | output | VPN_W | Page table write index |
| pt_wr_data | output | PPN_W+2 | Page table entry to write |

## Verification
The bench builds the block with a 4-entry buffer, a 6-bit page number (a 64-entry table model answering two cycles after each read), an 8-bit offset and an 8-bit physical page number. Because the buffer is that small, a handful of misses fills it, so free-slot filling, round-robin eviction that ignores recent hits, and refill after flush can all be reached in a short run. The narrow offset lets the extreme offsets 0x00 and 0xFF be tried directly.

// File: rtl/vat_pkg.sv
package vat_pkg;
  typedef enum logic [0:0] {
    WALK_IDLE = 1'b0,
    WALK_WAIT = 1'b1
  } walk_state_e;
endpackage

// File: rtl/vat_tlb.sv
module vat_tlb #(
  parameter int ENTRIES = 16,
  parameter int VPN_W   = 20,
  parameter int PPN_W   = 16,
  parameter int IDX_W   = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic [VPN_W-1:0] lk_vpn,
  output logic             lk_hit,
  output logic [IDX_W-1:0] lk_idx,
  output logic [PPN_W-1:0] lk_ppn,
  output logic             lk_dirty,
  input  logic             set_dirty_en,
  input  logic [IDX_W-1:0] set_dirty_idx,
  input  logic             fill_en,
  input  logic [VPN_W-1:0] fill_vpn,
  input  logic [PPN_W-1:0] fill_ppn,
  input  logic             fill_dirty
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ENTRIES - 1);

  logic [ENTRIES-1:0] valid_q, valid_d;
  logic [VPN_W-1:0]   vpn_q   [ENTRIES];
  logic [PPN_W-1:0]   ppn_q   [ENTRIES];
  logic [ENTRIES-1:0] dirty_q;
  logic [ENTRIES-1:0] match;
  logic [ENTRIES-1:0] we_fill;
  logic [IDX_W-1:0]   rr_q, rr_d;
  logic [IDX_W-1:0]   free_idx, victim;
  logic               any_free;

  // Parallel tag compare, one comparator per entry
  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign match[g]   = valid_q[g] && (vpn_q[g] == lk_vpn);
    assign we_fill[g] = fill_en && !flush && (victim == IDX_W'(g));
  end

  always_comb begin
    lk_idx   = '0;
    lk_ppn   = '0;
    lk_dirty = 1'b0;
    for (int i = 0; i < ENTRIES; i++) begin
      lk_idx   = lk_idx | (IDX_W'(i) & {IDX_W{match[i]}});
      lk_ppn   = lk_ppn | (ppn_q[i] & {PPN_W{match[i]}});
      lk_dirty = lk_dirty | (dirty_q[i] & match[i]);
    end
  end
  assign lk_hit = |match;

  // Lowest empty slot wins; otherwise the round-robin pointer
  always_comb begin
    free_idx = '0;
    any_free = 1'b0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!valid_q[i]) begin
        any_free = 1'b1;
        free_idx = IDX_W'(i);
      end
    end
    victim = any_free ? free_idx : rr_q;
  end

  always_comb begin
    valid_d = valid_q | we_fill;
    rr_d    = rr_q;
    if (fill_en && !any_free)
      rr_d = (rr_q == LAST_IDX) ? '0 : rr_q + 1'b1;
    if (flush) begin
      valid_d = '0;
      rr_d    = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      rr_q    <= '0;
    end else begin
      valid_q <= valid_d;
      rr_q    <= rr_d;
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < ENTRIES; i++) begin
      if (we_fill[i]) begin
        vpn_q[i]   <= fill_vpn;
        ppn_q[i]   <= fill_ppn;
        dirty_q[i] <= fill_dirty;
      end else if (set_dirty_en && (set_dirty_idx == IDX_W'(i))) begin
        dirty_q[i] <= 1'b1;
      end
    end
  end

  // R5 / R8: at most one entry may hold a given page
  a_r5_single_match: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(match));

  // R9: flush leaves no valid entry behind
  a_r9_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (valid_q == '0));

  // R5: a refill lands as a valid entry with the requested page number
  a_r5_fill_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_en && !flush) |=> (valid_q[$past(victim)] && (vpn_q[$past(victim)] == $past(fill_vpn))));

  // R8: with the buffer full, every eviction moves the pointer
  a_r8_rr_moves: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_en && !flush && (&valid_q)) |=> (rr_q != $past(rr_q)));
endmodule

// File: rtl/vat_walker.sv
module vat_walker
  import vat_pkg::*;
#(
  parameter int VPN_W = 20,
  parameter int OFF_W = 12,
  parameter int PPN_W = 16,
  parameter int IDX_W = 4,
  parameter int VA_W  = VPN_W + OFF_W,
  parameter int PA_W  = PPN_W + OFF_W,
  parameter int PTE_W = PPN_W + 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic [VA_W-1:0]  req_vaddr,
  output logic             req_ready,
  output logic             resp_valid,
  output logic             resp_tlb_hit,
  output logic             resp_fault,
  output logic [PA_W-1:0]  resp_paddr,
  output logic [VPN_W-1:0] lk_vpn,
  input  logic             lk_hit,
  input  logic [IDX_W-1:0] lk_idx,
  input  logic [PPN_W-1:0] lk_ppn,
  input  logic             lk_dirty,
  output logic             set_dirty_en,
  output logic [IDX_W-1:0] set_dirty_idx,
  output logic             fill_en,
  output logic [VPN_W-1:0] fill_vpn,
  output logic [PPN_W-1:0] fill_ppn,
  output logic             fill_dirty,
  output logic             pt_rd_en,
  output logic [VPN_W-1:0] pt_rd_idx,
  input  logic             pt_rd_ack,
  input  logic [PTE_W-1:0] pt_rd_data,
  output logic             pt_wr_en,
  output logic [VPN_W-1:0] pt_wr_idx,
  output logic [PTE_W-1:0] pt_wr_data
);
  localparam int V_BIT = PPN_W + 1;
  localparam int D_BIT = PPN_W;

  walk_state_e      state_q, state_d;
  logic [VPN_W-1:0] vpn_q;
  logic [OFF_W-1:0] off_q;
  logic             wr_q;
  logic             cap_en, accept;
  logic             resp_valid_d, resp_hit_d, resp_fault_d;
  logic [PA_W-1:0]  resp_paddr_d;
  logic             pt_rd_en_d, pt_wr_en_d;
  logic [VPN_W-1:0] pt_wr_idx_d;
  logic [PTE_W-1:0] pt_wr_data_d;
  logic             pte_valid, pte_dirty;
  logic [PPN_W-1:0] pte_ppn;
  logic [OFF_W-1:0] req_off;

  assign lk_vpn    = req_vaddr[VA_W-1:OFF_W];
  assign req_off   = req_vaddr[OFF_W-1:0];
  assign req_ready = (state_q == WALK_IDLE) && !flush;
  assign accept    = req_ready && req_valid;
  assign pte_valid = pt_rd_data[V_BIT];
  assign pte_dirty = pt_rd_data[D_BIT];
  assign pte_ppn   = pt_rd_data[PPN_W-1:0];

  assign fill_vpn      = vpn_q;
  assign fill_ppn      = pte_ppn;
  assign fill_dirty    = pte_dirty | wr_q;
  assign set_dirty_idx = lk_idx;
  assign pt_rd_idx     = vpn_q;

  always_comb begin
    state_d      = state_q;
    cap_en       = 1'b0;
    resp_valid_d = 1'b0;
    resp_hit_d   = 1'b0;
    resp_fault_d = 1'b0;
    resp_paddr_d = '0;
    pt_rd_en_d   = 1'b0;
    pt_wr_en_d   = 1'b0;
    pt_wr_idx_d  = lk_vpn;
    pt_wr_data_d = {1'b1, 1'b1, lk_ppn};
    set_dirty_en = 1'b0;
    fill_en      = 1'b0;
    unique case (state_q)
      WALK_IDLE: begin
        if (accept) begin
          if (lk_hit) begin
            resp_valid_d = 1'b1;
            resp_hit_d   = 1'b1;
            resp_paddr_d = {lk_ppn, req_off};
            if (req_write && !lk_dirty) begin
              set_dirty_en = 1'b1;
              pt_wr_en_d   = 1'b1;
            end
          end else begin
            cap_en     = 1'b1;
            pt_rd_en_d = 1'b1;
            state_d    = WALK_WAIT;
          end
        end
      end
      WALK_WAIT: begin
        pt_wr_idx_d  = vpn_q;
        pt_wr_data_d = {1'b1, 1'b1, pte_ppn};
        if (pt_rd_ack) begin
          state_d      = WALK_IDLE;
          resp_valid_d = 1'b1;
          if (pte_valid) begin
            resp_paddr_d = {pte_ppn, off_q};
            fill_en      = 1'b1;
            pt_wr_en_d   = wr_q && !pte_dirty;
          end else begin
            resp_fault_d = 1'b1;
          end
        end
      end
      default: state_d = WALK_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q      <= WALK_IDLE;
      resp_valid   <= 1'b0;
      resp_tlb_hit <= 1'b0;
      resp_fault   <= 1'b0;
      pt_rd_en     <= 1'b0;
      pt_wr_en     <= 1'b0;
    end else begin
      state_q      <= state_d;
      resp_valid   <= resp_valid_d;
      resp_tlb_hit <= resp_hit_d;
      resp_fault   <= resp_fault_d;
      pt_rd_en     <= pt_rd_en_d;
      pt_wr_en     <= pt_wr_en_d;
    end
  end

  always_ff @(posedge clk) begin
    if (cap_en) begin
      vpn_q <= lk_vpn;
      off_q <= req_off;
      wr_q  <= req_write;
    end
    if (resp_valid_d) resp_paddr <= resp_paddr_d;
    if (pt_wr_en_d) begin
      pt_wr_idx  <= pt_wr_idx_d;
      pt_wr_data <= pt_wr_data_d;
    end
  end

  // R2: a buffer hit answers next cycle without a table read
  a_r2_hit_no_walk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && lk_hit) |=> (resp_valid && resp_tlb_hit && !pt_rd_en));

  // R3: a buffer miss reads the table at the request's page number
  a_r3_miss_reads: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !lk_hit) |=> (pt_rd_en && (pt_rd_idx == $past(lk_vpn)) && !resp_valid));

  // R4: a fault never claims a buffer hit and carries a zero address
  a_r4_fault_shape: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && resp_fault) |-> (!resp_tlb_hit && (resp_paddr == '0)));

  // R7: write-backs always mark the entry valid and dirty
  a_r7_wb_marks: assert property (@(posedge clk) disable iff (!rst_n)
    pt_wr_en |-> (pt_wr_data[V_BIT] && pt_wr_data[D_BIT]));

  // R11: no new request is taken while a read is in flight
  a_r11_busy: assert property (@(posedge clk) disable iff (!rst_n)
    pt_rd_en |-> !req_ready);
endmodule

// File: rtl/vat_mmu.sv
module vat_mmu #(
  parameter int VPN_W       = 20,
  parameter int OFF_W       = 12,
  parameter int PPN_W       = 16,
  parameter int TLB_ENTRIES = 16,
  parameter int VA_W        = VPN_W + OFF_W,
  parameter int PA_W        = PPN_W + OFF_W,
  parameter int PTE_W       = PPN_W + 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic [VA_W-1:0]  req_vaddr,
  output logic             req_ready,
  output logic             resp_valid,
  output logic             resp_tlb_hit,
  output logic             resp_fault,
  output logic [PA_W-1:0]  resp_paddr,
  output logic             pt_rd_en,
  output logic [VPN_W-1:0] pt_rd_idx,
  input  logic             pt_rd_ack,
  input  logic [PTE_W-1:0] pt_rd_data,
  output logic             pt_wr_en,
  output logic [VPN_W-1:0] pt_wr_idx,
  output logic [PTE_W-1:0] pt_wr_data
);
  localparam int IDX_W = $clog2(TLB_ENTRIES);

  logic [VPN_W-1:0] lk_vpn;
  logic             lk_hit, lk_dirty;
  logic [IDX_W-1:0] lk_idx;
  logic [PPN_W-1:0] lk_ppn;
  logic             set_dirty_en;
  logic [IDX_W-1:0] set_dirty_idx;
  logic             fill_en, fill_dirty;
  logic [VPN_W-1:0] fill_vpn;
  logic [PPN_W-1:0] fill_ppn;

  vat_tlb #(
    .ENTRIES(TLB_ENTRIES), .VPN_W(VPN_W), .PPN_W(PPN_W), .IDX_W(IDX_W)
  ) u_tlb (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .lk_vpn(lk_vpn), .lk_hit(lk_hit), .lk_idx(lk_idx),
    .lk_ppn(lk_ppn), .lk_dirty(lk_dirty),
    .set_dirty_en(set_dirty_en), .set_dirty_idx(set_dirty_idx),
    .fill_en(fill_en), .fill_vpn(fill_vpn), .fill_ppn(fill_ppn),
    .fill_dirty(fill_dirty)
  );

  vat_walker #(
    .VPN_W(VPN_W), .OFF_W(OFF_W), .PPN_W(PPN_W), .IDX_W(IDX_W),
    .VA_W(VA_W), .PA_W(PA_W), .PTE_W(PTE_W)
  ) u_walk (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .req_valid(req_valid), .req_write(req_write), .req_vaddr(req_vaddr),
    .req_ready(req_ready),
    .resp_valid(resp_valid), .resp_tlb_hit(resp_tlb_hit),
    .resp_fault(resp_fault), .resp_paddr(resp_paddr),
    .lk_vpn(lk_vpn), .lk_hit(lk_hit), .lk_idx(lk_idx),
    .lk_ppn(lk_ppn), .lk_dirty(lk_dirty),
    .set_dirty_en(set_dirty_en), .set_dirty_idx(set_dirty_idx),
    .fill_en(fill_en), .fill_vpn(fill_vpn), .fill_ppn(fill_ppn),
    .fill_dirty(fill_dirty),
    .pt_rd_en(pt_rd_en), .pt_rd_idx(pt_rd_idx),
    .pt_rd_ack(pt_rd_ack), .pt_rd_data(pt_rd_data),
    .pt_wr_en(pt_wr_en), .pt_wr_idx(pt_wr_idx), .pt_wr_data(pt_wr_data)
  );

  // R10: no strobes while reset is held
  a_r10_quiet_in_reset: assert property (@(posedge clk)
    !rst_n |-> (!resp_valid && !pt_rd_en && !pt_wr_en));
endmodule

// File: tb/vat_mmu_test.sv
module vat_mmu_test;
  localparam int VPN_W = 6;
  localparam int OFF_W = 8;
  localparam int PPN_W = 8;
  localparam int ENT   = 4;
  localparam int VA_W  = VPN_W + OFF_W;
  localparam int PA_W  = PPN_W + OFF_W;
  localparam int PTE_W = PPN_W + 2;

  logic clk = 1'b0;
  logic rst_n, flush, req_valid, req_write;
  logic [VA_W-1:0] req_vaddr;
  logic req_ready, resp_valid, resp_tlb_hit, resp_fault;
  logic [PA_W-1:0] resp_paddr;
  logic pt_rd_en, pt_rd_ack, pt_wr_en;
  logic [VPN_W-1:0] pt_rd_idx, pt_wr_idx;
  logic [PTE_W-1:0] pt_rd_data, pt_wr_data;

  always #2.5 clk = ~clk;

  vat_mmu #(.VPN_W(VPN_W), .OFF_W(OFF_W), .PPN_W(PPN_W), .TLB_ENTRIES(ENT)) uut (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .req_valid(req_valid), .req_write(req_write), .req_vaddr(req_vaddr),
    .req_ready(req_ready), .resp_valid(resp_valid), .resp_tlb_hit(resp_tlb_hit),
    .resp_fault(resp_fault), .resp_paddr(resp_paddr),
    .pt_rd_en(pt_rd_en), .pt_rd_idx(pt_rd_idx), .pt_rd_ack(pt_rd_ack),
    .pt_rd_data(pt_rd_data), .pt_wr_en(pt_wr_en), .pt_wr_idx(pt_wr_idx),
    .pt_wr_data(pt_wr_data)
  );

  int checks = 0, errors = 0, cyc = 0, rd_cnt = 0, wr_cnt = 0;
  bit done = 0;

  // Page table model: entry = {valid, dirty, ppn}, answered two cycles later
  logic [PTE_W-1:0] pt_mem [64];
  logic [VPN_W-1:0] lat_idx;
  int lat_cnt = 0;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    pt_rd_ack <= 1'b0;
    if (pt_wr_en) begin
      pt_mem[pt_wr_idx] <= pt_wr_data;
      wr_cnt <= wr_cnt + 1;
    end
    if (pt_rd_en) begin
      rd_cnt  <= rd_cnt + 1;
      lat_idx <= pt_rd_idx;
      lat_cnt <= 2;
    end else if (lat_cnt != 0) begin
      lat_cnt <= lat_cnt - 1;
      if (lat_cnt == 1) begin
        pt_rd_ack  <= 1'b1;
        pt_rd_data <= pt_mem[lat_idx];
      end
    end
  end

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  typedef struct {
    bit hit; bit fault; logic [PA_W-1:0] paddr; int reads; int issue; string tag;
  } exp_t;
  exp_t sb[$];

  // Monitor: pops one expected item per response
  always @(negedge clk) begin
    if (rst_n && resp_valid) begin
      if (sb.size() == 0) begin
        check(0, "R11", "unexpected response", 1, 0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        check(resp_tlb_hit == e.hit, e.tag, "tlb_hit", resp_tlb_hit, e.hit);
        check(resp_fault == e.fault, e.tag, "fault", resp_fault, e.fault);
        check(resp_paddr == e.paddr, e.tag, "paddr", resp_paddr, e.paddr);
        check(rd_cnt == e.reads, e.tag, "table reads", rd_cnt, e.reads);
        if (e.hit) check(cyc == e.issue + 1, "R2", "hit latency", cyc - e.issue, 1);
      end
    end
  end

  task automatic push_exp(input bit wr, input int vpn, input int off,
                          input bit hit, input bit fault, input string tag);
    exp_t e;
    e.hit   = hit;
    e.fault = fault;
    e.paddr = fault ? '0 : {pt_mem[vpn][PPN_W-1:0], OFF_W'(off)};
    e.reads = rd_cnt + (hit ? 0 : 1);
    e.issue = cyc;
    e.tag   = tag;
    sb.push_back(e);
    req_valid = 1'b1;
    req_write = wr;
    req_vaddr = {VPN_W'(vpn), OFF_W'(off)};
  endtask

  task automatic drain();
    while (sb.size() != 0) @(negedge clk);
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic issue(input bit wr, input int vpn, input int off,
                       input bit hit, input bit fault, input string tag);
    while (!req_ready) @(negedge clk);
    push_exp(wr, vpn, off, hit, fault, tag);
    @(negedge clk);
    req_valid = 1'b0;
    drain();
  endtask

  task automatic set_pte(input int vpn, input bit v, input bit d, input int ppn);
    pt_mem[vpn] = {v, d, PPN_W'(ppn)};
  endtask

  task automatic do_flush();
    @(negedge clk);
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
  endtask

  initial begin
    int w0;
    rst_n = 1'b0; flush = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_vaddr = '0;
    for (int v = 0; v < 64; v++) pt_mem[v] = '0;
    for (int v = 1; v < 41; v++) set_pte(v, 1'b1, 1'b0, (v * 37 + 11) & 8'hFF);
    set_pte(13, 1'b1, 1'b1, 8'h6D);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready == 1'b1, "R10", "req_ready after reset", req_ready, 1);
    check(resp_valid == 1'b0, "R10", "resp_valid after reset", resp_valid, 0);
    check(!pt_rd_en && !pt_wr_en, "R10", "table strobes after reset", {pt_rd_en, pt_wr_en}, 0);

    // R3 miss, then R2 hits with R1 offset extremes
    issue(0, 5, 'h3C, 0, 0, "R3");
    issue(0, 5, 'hFF, 1, 0, "R2");
    issue(0, 5, 'h00, 1, 0, "R1");

    // R4 faults: no refill, no write-back
    issue(0, 50, 'h10, 0, 1, "R4");
    issue(0, 50, 'h10, 0, 1, "R4");
    w0 = wr_cnt;
    issue(1, 50, 'h11, 0, 1, "R4");
    check(wr_cnt == w0, "R7", "faulting write wrote table", wr_cnt, w0);
    set_pte(50, 1'b1, 1'b0, 8'hC3);
    issue(0, 50, 'h21, 0, 0, "R5");
    issue(0, 50, 'h22, 1, 0, "R5");

    // R7 dirty on the hit path
    issue(0, 10, 'h01, 0, 0, "R7");
    w0 = wr_cnt;
    issue(0, 10, 'h02, 1, 0, "R7");
    check(wr_cnt == w0, "R7", "read wrote table", wr_cnt, w0);
    issue(1, 10, 'h03, 1, 0, "R7");
    check(wr_cnt == w0 + 1, "R7", "write-back count", wr_cnt, w0 + 1);
    check(pt_mem[10] == {2'b11, 8'((10 * 37 + 11) & 8'hFF)}, "R7", "entry 10",
          pt_mem[10], {2'b11, 8'((10 * 37 + 11) & 8'hFF)});
    issue(1, 10, 'h04, 1, 0, "R7");
    check(wr_cnt == w0 + 1, "R7", "repeat write wrote table", wr_cnt, w0 + 1);

    // R7 dirty on the walk path
    w0 = wr_cnt;
    issue(1, 11, 'h05, 0, 0, "R7");
    check(wr_cnt == w0 + 1 && pt_mem[11][PPN_W] == 1'b1, "R7", "walk write-back",
          wr_cnt, w0 + 1);
    issue(1, 11, 'h06, 1, 0, "R7");
    check(wr_cnt == w0 + 1, "R7", "repeat walk write", wr_cnt, w0 + 1);

    // R6: entry already dirty (bit PPN_W) needs no write-back; buffer full, evicts entry 0
    w0 = wr_cnt;
    issue(1, 13, 'h07, 0, 0, "R6");
    check(wr_cnt == w0, "R6", "pre-dirty entry written", wr_cnt, w0);
    issue(0, 5, 'h08, 0, 0, "R8");

    // R11: a request offered during a walk is ignored
    while (!req_ready) @(negedge clk);
    push_exp(0, 20, 'h09, 0, 0, "R11");
    @(negedge clk);
    req_valid = 1'b0;
    check(req_ready == 1'b0, "R11", "ready during walk", req_ready, 0);
    req_valid = 1'b1;
    req_vaddr = {VPN_W'(21), OFF_W'(8'h0A)};
    @(negedge clk);
    check(req_ready == 1'b0, "R11", "ready during walk", req_ready, 0);
    req_valid = 1'b0;
    drain();
    issue(0, 21, 'h0B, 0, 0, "R11");

    // R9 flush
    issue(0, 21, 'h0C, 1, 0, "R9");
    do_flush();
    issue(0, 21, 'h0D, 0, 0, "R9");

    // R8 replacement: free slots first, then round robin ignoring hits
    do_flush();
    issue(0, 30, 'h10, 0, 0, "R8");
    issue(0, 31, 'h11, 0, 0, "R8");
    issue(0, 32, 'h12, 0, 0, "R8");
    issue(0, 33, 'h13, 0, 0, "R8");
    issue(0, 30, 'h14, 1, 0, "R8");
    issue(0, 34, 'h15, 0, 0, "R8");
    issue(0, 30, 'h16, 0, 0, "R8");
    issue(0, 32, 'h17, 1, 0, "R8");
    issue(0, 33, 'h18, 1, 0, "R8");
    issue(0, 34, 'h19, 1, 0, "R8");
    issue(0, 31, 'h1A, 0, 0, "R8");
    issue(0, 32, 'h1B, 0, 0, "R8");
    issue(0, 30, 'h1C, 1, 0, "R8");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    if (cyc == 20000 && !done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule